// File: doc/BRIEF.md
# Privilege-Level Register Access Trap Arbiter

This block decides, for a single access to a privileged system register, whether that access may complete or must be diverted as a trap to a higher privilege level. It sees the current privilege level (0 to 3) and the access direction (read or write). Its control inputs are: the enable state of level 2 and the presence of level 3, two user-mode access enables, two routing bits held at level 2, a read trap bit and a write trap bit (both fine-grained), a level-3 enable for those fine-grained traps, and one trap-monitor bit at each of levels 2 and 3. It evaluates a strict priority chain that depends on the current level and returns one registered decision.

A request is one cycle of `req_valid`. The decision appears on the outputs in the next cycle, qualified by `resp_valid`. There is no back-pressure: the block accepts a request in every cycle, and the consumer must take each result in the cycle it is presented. Back-to-back requests produce back-to-back results. All levels are treated as 64-bit execution states.

Top module: `access_trap_arbiter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `resp_valid`, `allow` and `trap_valid` are 0.
- R2: `resp_valid` is high exactly in the cycle after a cycle with `req_valid` high. When `resp_valid` is high, exactly one of `allow` and `trap_valid` is high. When it is low, both are low.
- R3: User check, level 0 only. A read traps when `usr_rd_en` and `usr_cnt_en` are both 0. A write traps when `usr_cnt_en` is 0, whatever `usr_rd_en` is. This check outranks every other check, and it is not made at levels 1 to 3.
- R4: The user-check trap goes to level 2 when `l2_enabled` and `route_tge` are both 1. Otherwise it goes to level 1.
- R5: Second in priority at levels 0 and 1 is the fine-grained check. The trap bit used is `fg_rd_trap` for a read and `fg_wr_trap` for a write. It traps to level 2 only when `l2_enabled` is 1 and either `l3_present` is 0 or `fg_l3_enable` is 1.
- R6: At level 0 only, the fine-grained check is suppressed when `host_e2h` and `route_tge` are both 1.
- R7: At levels 0 and 1, after the fine-grained check, `mon_l2` traps to level 2. After that, `mon_l3` traps to level 3.
- R8: At level 2, only `mon_l3` is checked. At level 3, every access is allowed. A trap always targets a level above the current one.
- R9: Checks that involve level 2 have no effect when `l2_enabled` is 0. Checks that involve level 3 (`mon_l3`, the `fg_l3_enable` gate) have no effect when `l3_present` is 0.
- R10: `trap_lvl` holds the target level in binary (1, 2 or 3). `trap_class` is 0x18 on every trap. When the access is allowed, both fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle strobe that marks an access request |
| cur_lvl | input | 2 | Current privilege level, 0 to 3 |
| is_write | input | 1 | 1 = write access, 0 = read access |
| l2_enabled | input | 1 | Level 2 is implemented and enabled |
| l3_present | input | 1 | Level 3 is implemented |
| usr_rd_en | input | 1 | User-mode read enable |
| usr_cnt_en | input | 1 | User-mode counter access enable |
| route_tge | input | 1 | Level-2 general exception routing bit |
| host_e2h | input | 1 | Level-2 host extension bit |
| fg_rd_trap | input | 1 | Fine-grained read trap bit |
| fg_wr_trap | input | 1 | Fine-grained write trap bit |
| fg_l3_enable | input | 1 | Level-3 enable for fine-grained traps |
| mon_l2 | input | 1 | Level-2 trap-monitor bit |
| mon_l3 | input | 1 | Level-3 trap-monitor bit |
| resp_valid | output | 1 | Decision valid, one cycle after the request |
| allow | output | 1 | Access completes |
| trap_valid | output | 1 | Access traps |
| trap_lvl | output | 2 | Target level of the trap |
| trap_class | output | EC_W | Syndrome exception class of the trap |

## Verification
The bench builds the block with its default parameters: a 6-bit class field and a trap class value of 0x18. With these, the exact class encoding can be compared on every trap. The vector table reaches each rung of the priority chain at every level, each read/write split in the user and fine-grained checks, and each absent-level gate. Directed tests then cover reset, idle cycles between requests, and back-to-back requests with different outcomes.

// File: rtl/acc_trap_pkg.sv
package acc_trap_pkg;

  typedef enum logic [1:0] {
    PL0 = 2'd0,
    PL1 = 2'd1,
    PL2 = 2'd2,
    PL3 = 2'd3
  } plvl_t;

  // Control bits that steer the trap decision
  typedef struct packed {
    logic el2_on;
    logic el3_here;
    logic usr_rd;
    logic usr_cnt;
    logic route_tge;
    logic host_e2h;
    logic fg_rd;
    logic fg_wr;
    logic fg_l3_en;
    logic mon_l2;
    logic mon_l3;
  } trap_ctl_t;

  // One rule's verdict: does it fire, and where does it send the trap
  typedef struct packed {
    logic  hit;
    plvl_t tgt;
  } rule_hit_t;

  localparam int unsigned NUM_RULES = 4;

endpackage

// File: rtl/trap_rule_eval.sv
module trap_rule_eval
  import acc_trap_pkg::*;
(
  input  plvl_t                      lvl,
  input  logic                       is_wr,
  input  trap_ctl_t                  ctl,
  output rule_hit_t [NUM_RULES-1:0]  hits
);

  // Index 0 carries the highest priority
  localparam int unsigned IDX_USR  = 0;
  localparam int unsigned IDX_FG   = 1;
  localparam int unsigned IDX_MON2 = 2;
  localparam int unsigned IDX_MON3 = 3;

  logic low_lvl;
  logic usr_block;
  logic fg_bit;
  logic fg_gate;
  logic fg_host_veto;

  always_comb begin
    low_lvl      = (lvl == PL0) || (lvl == PL1);
    usr_block    = is_wr ? !ctl.usr_cnt : !(ctl.usr_rd || ctl.usr_cnt);
    fg_bit       = is_wr ? ctl.fg_wr : ctl.fg_rd;
    fg_gate      = ctl.el2_on && (!ctl.el3_here || ctl.fg_l3_en);
    fg_host_veto = (lvl == PL0) && ctl.host_e2h && ctl.route_tge;

    hits = '0;

    hits[IDX_USR].hit  = (lvl == PL0) && usr_block;
    hits[IDX_USR].tgt  = (ctl.el2_on && ctl.route_tge) ? PL2 : PL1;

    hits[IDX_FG].hit   = low_lvl && fg_gate && fg_bit && !fg_host_veto;
    hits[IDX_FG].tgt   = PL2;

    hits[IDX_MON2].hit = low_lvl && ctl.el2_on && ctl.mon_l2;
    hits[IDX_MON2].tgt = PL2;

    hits[IDX_MON3].hit = (lvl != PL3) && ctl.el3_here && ctl.mon_l3;
    hits[IDX_MON3].tgt = PL3;
  end

endmodule

// File: rtl/trap_prio_pick.sv
module trap_prio_pick
  import acc_trap_pkg::*;
#(
  parameter int unsigned N = NUM_RULES
) (
  input  rule_hit_t [N-1:0] hits,
  output rule_hit_t         pick
);

  // Lowest index wins
  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i].hit) pick = hits[i];
    end
  end

endmodule

// File: rtl/trap_out_stage.sv
module trap_out_stage
  import acc_trap_pkg::*;
#(
  parameter int unsigned     EC_W   = 6,
  parameter logic [EC_W-1:0] EC_VAL = 6'h18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  rule_hit_t       pick,
  output logic            resp_valid,
  output logic            allow,
  output logic            trap_valid,
  output logic [1:0]      trap_lvl,
  output logic [EC_W-1:0] trap_class
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      allow      <= 1'b0;
      trap_valid <= 1'b0;
      trap_lvl   <= 2'd0;
      trap_class <= '0;
    end else begin
      resp_valid <= req_valid;
      allow      <= req_valid && !pick.hit;
      trap_valid <= req_valid && pick.hit;
      trap_lvl   <= (req_valid && pick.hit) ? pick.tgt : 2'd0;
      trap_class <= (req_valid && pick.hit) ? EC_VAL : '0;
    end
  end

  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $onehot({allow, trap_valid}));

  assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> !allow && !trap_valid);

  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  assert_class_on_trap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> trap_class == EC_VAL && trap_lvl != 2'd0);

  assert_zero_on_allow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    allow |-> trap_class == '0 && trap_lvl == 2'd0);

endmodule

// File: rtl/access_trap_arbiter.sv
module access_trap_arbiter
  import acc_trap_pkg::*;
#(
  parameter int unsigned     EC_W   = 6,
  parameter logic [EC_W-1:0] EC_VAL = 6'h18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [1:0]      cur_lvl,
  input  logic            is_write,
  input  logic            l2_enabled,
  input  logic            l3_present,
  input  logic            usr_rd_en,
  input  logic            usr_cnt_en,
  input  logic            route_tge,
  input  logic            host_e2h,
  input  logic            fg_rd_trap,
  input  logic            fg_wr_trap,
  input  logic            fg_l3_enable,
  input  logic            mon_l2,
  input  logic            mon_l3,
  output logic            resp_valid,
  output logic            allow,
  output logic            trap_valid,
  output logic [1:0]      trap_lvl,
  output logic [EC_W-1:0] trap_class
);

  trap_ctl_t                 ctl;
  plvl_t                     lvl;
  rule_hit_t [NUM_RULES-1:0] hits;
  rule_hit_t                 pick;

  always_comb begin
    lvl           = plvl_t'(cur_lvl);
    ctl.el2_on    = l2_enabled;
    ctl.el3_here  = l3_present;
    ctl.usr_rd    = usr_rd_en;
    ctl.usr_cnt   = usr_cnt_en;
    ctl.route_tge = route_tge;
    ctl.host_e2h  = host_e2h;
    ctl.fg_rd     = fg_rd_trap;
    ctl.fg_wr     = fg_wr_trap;
    ctl.fg_l3_en  = fg_l3_enable;
    ctl.mon_l2    = mon_l2;
    ctl.mon_l3    = mon_l3;
  end

  trap_rule_eval u_rules (
    .lvl   (lvl),
    .is_wr (is_write),
    .ctl   (ctl),
    .hits  (hits)
  );

  trap_prio_pick #(.N(NUM_RULES)) u_pick (
    .hits (hits),
    .pick (pick)
  );

  trap_out_stage #(.EC_W(EC_W), .EC_VAL(EC_VAL)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .pick       (pick),
    .resp_valid (resp_valid),
    .allow      (allow),
    .trap_valid (trap_valid),
    .trap_lvl   (trap_lvl),
    .trap_class (trap_class)
  );

  // Level 3 accesses always complete
  assert_top_lvl_allow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && cur_lvl == 2'd3 |=> allow);

  // A trap always climbs above the requesting level
  assert_trap_climbs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && pick.hit |=> trap_lvl > $past(cur_lvl));

  // No trap lands on an absent level 3
  assert_no_absent_l3_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !l3_present |=> trap_lvl != 2'd3);

endmodule

// File: tb/access_trap_arbiter_test.sv
module access_trap_arbiter_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [1:0] cur_lvl;
  logic       is_write, l2_enabled, l3_present, usr_rd_en, usr_cnt_en;
  logic       route_tge, host_e2h, fg_rd_trap, fg_wr_trap, fg_l3_enable;
  logic       mon_l2, mon_l3;
  logic       resp_valid, allow, trap_valid;
  logic [1:0] trap_lvl;
  logic [5:0] trap_class;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  access_trap_arbiter uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cur_lvl(cur_lvl),
    .is_write(is_write), .l2_enabled(l2_enabled), .l3_present(l3_present),
    .usr_rd_en(usr_rd_en), .usr_cnt_en(usr_cnt_en), .route_tge(route_tge),
    .host_e2h(host_e2h), .fg_rd_trap(fg_rd_trap), .fg_wr_trap(fg_wr_trap),
    .fg_l3_enable(fg_l3_enable), .mon_l2(mon_l2), .mon_l3(mon_l3),
    .resp_valid(resp_valid), .allow(allow), .trap_valid(trap_valid),
    .trap_lvl(trap_lvl), .trap_class(trap_class)
  );

  // lvl | wr el2 el3 urd ucnt tge e2h fgr fgw fg3 m2 m3 | allow | tgt
  localparam int NV = 25;
  localparam logic [16:0] VEC [NV] = '{
    17'b00_0_0_0_0_0_0_0_0_0_0_0_0_0_01, // R3 read, both user bits clear
    17'b00_0_0_0_1_0_0_0_0_0_0_0_0_1_00, // R3 read, user read enable
    17'b00_0_0_0_0_1_0_0_0_0_0_0_0_1_00, // R3 read, counter enable
    17'b00_1_0_0_1_0_0_0_0_0_0_0_0_0_01, // R3 write ignores read enable
    17'b00_1_0_0_0_1_0_0_0_0_0_0_0_1_00, // R3 write with counter enable
    17'b00_0_1_0_0_0_1_0_0_0_0_0_0_0_10, // R4 routed to level 2
    17'b00_0_0_0_0_0_1_0_0_0_0_0_0_0_01, // R4 R9 routing ignored, l2 off
    17'b00_0_1_0_1_0_0_0_1_0_0_0_0_0_10, // R5 read fg bit, l3 absent
    17'b00_1_1_0_0_1_0_0_1_0_0_0_0_1_00, // R5 write ignores read fg bit
    17'b00_1_1_0_0_1_0_0_0_1_0_0_0_0_10, // R5 write fg bit
    17'b01_0_1_1_0_0_0_0_1_0_0_0_0_1_00, // R5 l3 present, fg gate off
    17'b01_0_1_1_0_0_0_0_1_0_1_0_0_0_10, // R5 l3 present, fg gate on
    17'b00_0_1_0_1_0_1_1_1_0_0_0_0_1_00, // R6 host pair vetoes fg at lvl0
    17'b01_0_1_0_0_0_1_1_1_0_0_0_0_0_10, // R6 no veto at lvl1
    17'b01_0_1_1_0_0_0_0_0_0_0_1_1_0_10, // R7 mon2 beats mon3
    17'b01_0_1_1_0_0_0_0_0_0_0_0_1_0_11, // R7 mon3 alone
    17'b01_0_0_0_0_0_0_0_0_0_0_1_0_1_00, // R9 mon2 ignored, l2 off
    17'b01_0_0_0_0_0_0_0_0_0_0_0_1_1_00, // R9 mon3 ignored, l3 absent
    17'b10_0_1_1_0_0_0_0_1_0_1_1_0_1_00, // R8 lvl2 skips fg and mon2
    17'b10_0_1_1_0_0_0_0_0_0_0_0_1_0_11, // R8 lvl2 mon3
    17'b11_1_1_1_0_0_1_0_1_1_1_1_1_1_00, // R8 lvl3 never traps
    17'b00_0_0_1_0_0_0_0_0_0_0_0_1_0_01, // R3 user beats mon3
    17'b00_0_1_0_1_0_0_0_0_0_0_1_0_0_10, // R7 lvl0 mon2
    17'b01_1_1_0_0_0_0_0_0_1_0_0_0_0_10, // R5 l3 absent, fg write at lvl1
    17'b01_0_0_0_0_0_0_0_0_0_0_0_0_1_00  // R3 user check skipped at lvl1
  };

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_inputs(logic [16:0] v);
    cur_lvl      = v[16:15];
    is_write     = v[14];
    l2_enabled   = v[13];
    l3_present   = v[12];
    usr_rd_en    = v[11];
    usr_cnt_en   = v[10];
    route_tge    = v[9];
    host_e2h     = v[8];
    fg_rd_trap   = v[7];
    fg_wr_trap   = v[6];
    fg_l3_enable = v[5];
    mon_l2       = v[4];
    mon_l3       = v[3];
  endtask

  task automatic check_result(string tag, logic [16:0] v);
    check({tag, " resp_valid"}, resp_valid, 1);
    check({tag, " allow"}, allow, v[2]);
    check({tag, " trap_valid"}, trap_valid, !v[2]);
    check({tag, " trap_lvl"}, trap_lvl, v[1:0]);
    check({tag, " trap_class"}, trap_class, v[2] ? 0 : 'h18);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b1;
    set_inputs('0);
    repeat (3) @(negedge clk);
    check("R1 resp_valid in reset", resp_valid, 0);
    check("R1 allow in reset", allow, 0);
    check("R1 trap_valid in reset", trap_valid, 0);
    req_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 resp_valid after reset", resp_valid, 0);
    check("R1 trap_valid after reset", trap_valid, 0);

    for (int i = 0; i < NV; i++) begin
      set_inputs(VEC[i]);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check_result($sformatf("vec%0d", i), VEC[i]);
      @(negedge clk);
      check($sformatf("R2 idle after vec%0d resp_valid", i), resp_valid, 0);
      check($sformatf("R2 idle after vec%0d allow", i), allow, 0);
      check($sformatf("R2 idle after vec%0d trap_valid", i), trap_valid, 0);
    end

    // R2 back-to-back requests with different outcomes
    set_inputs(VEC[15]);
    req_valid = 1'b1;
    @(negedge clk);
    check_result("R2 back-to-back first", VEC[15]);
    set_inputs(VEC[1]);
    @(negedge clk);
    check_result("R2 back-to-back second", VEC[1]);
    set_inputs(VEC[5]);
    @(negedge clk);
    req_valid = 1'b0;
    check_result("R2 back-to-back third R4", VEC[5]);
    // R2 inputs changing with no strobe leave outputs quiet
    set_inputs(VEC[0]);
    @(negedge clk);
    @(negedge clk);
    check("R2 no strobe resp_valid", resp_valid, 0);
    check("R2 no strobe trap_valid", trap_valid, 0);

    // R1 reset in the middle of a response
    req_valid = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset resp_valid", resp_valid, 0);
    check("R1 mid-run reset trap_valid", trap_valid, 0);
    req_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule